// File: doc/BRIEF.md
# Serial SAR Converter Interface Power-State Model

This block is a synthesizable, device-side stand-in for a 12-bit serial-output successive-approximation converter. A host controller drives an active-low chip select and a serial clock; the model answers on a serial data line that it drives only while chip select is low. A parallel sample input replaces the analog input and is captured when chip select falls. Chip select and the serial clock are oversampled by the system clock, so the host may run the serial clock at any rate below a quarter of the system clock.

Inside, the model counts serial-clock falling edges in each frame. When chip select rises, that count decides the next power state. Early rises are treated as glitches. A rise in the middle band of the frame shuts the device down. A wake-up frame must run long enough to reach full power. Frames that do not come from full power return zeros and raise an invalid flag. The power state and the edge count are brought out so that a bench can check a host controller's shutdown and wake-up sequences.

Top module: `sar_serif_model`

## Requirements
- R1: During and after reset, power_state is normal (code 0), sdata_oe is 0, edge_cnt is 0 and frame_invalid is 0.
- R2: A chip-select fall captures sample_in into a 16-bit frame word made of four zero bits followed by the 12 sample bits, sent MSB first. Word bit 15 is on sdata once chip select is low. After the k-th serial-clock fall the line carries word bit 15-k. After the 16th fall it carries 0.
- R3: sdata_oe is 1 while chip select is low and 0 while it is high.
- R4: edge_cnt is cleared by a chip-select fall and counts serial-clock falls while chip select stays low. It saturates at 31.
- R5: In normal state (code 0), a chip-select rise after fewer than 2 falls leaves the state normal.
- R6: In normal state, a chip-select rise after 2 to 9 falls moves to shutdown (code 1).
- R7: In normal state, a chip-select rise after 10 or more falls leaves the state normal.
- R8: A chip-select fall in shutdown moves to powering-up (code 2).
- R9: In powering-up, a chip-select rise after fewer than 10 falls returns to shutdown.
- R10: In powering-up, the 16th serial-clock fall of a frame moves to normal. A rise after 10 to 15 falls leaves the state powering-up.
- R11: A frame whose chip-select fall finds the state other than normal sends all zeros, with frame_invalid 1 from that fall until the next fall. A frame begun in normal sets frame_invalid to 0.
- R12: Serial-clock edges while chip select is high change neither edge_cnt nor power_state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host signals |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host; idles high |
| sample_in | input | 12 | Value captured at the chip-select fall |
| sdata | output | 1 | Serial data, valid while sdata_oe is 1 |
| sdata_oe | output | 1 | Output enable for sdata; 0 means high impedance |
| frame_invalid | output | 1 | Current frame came from shutdown or powering-up |
| power_state | output | 2 | 0 normal, 1 shutdown, 2 powering-up |
| edge_cnt | output | 5 | Serial-clock falls in the current frame |

## Verification
The bench sweeps the chip-select rise position over every edge count from 0 to 19, once from normal and once in a wake-up frame from shutdown. This hits both sides of the 2, 10 and 16 thresholds, where an off-by-one design would shut down on a glitch, fail to shut down, or reach full power early. Data frames with several sample patterns check each bit position, so a design that shifted on the wrong edge or dropped the leading zeros would show a misplaced bit. Wake-up frames must carry zeros with the invalid flag set, and a long frame checks that the count saturates instead of wrapping.

// File: rtl/sar_serif_pkg.sv
package sar_serif_pkg;

    typedef enum logic [1:0] {
        PWR_NORMAL   = 2'd0,
        PWR_SHUTDOWN = 2'd1,
        PWR_WAKING   = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sck_fall;
    } edge_evt_t;

    // Next power state decided when chip select returns high.
    function automatic pwr_state_e state_on_rise(
        input pwr_state_e cur,
        input int         n,
        input int         sd_lo,
        input int         sd_hi
    );
        pwr_state_e nxt;
        nxt = cur;
        case (cur)
            PWR_NORMAL: if (n >= sd_lo && n < sd_hi) nxt = PWR_SHUTDOWN;
            PWR_WAKING: if (n < sd_hi) nxt = PWR_SHUTDOWN;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/sar_serif_edges.sv
module sar_serif_edges
    import sar_serif_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      sclk,
    output edge_evt_t evt
);
    logic cs_q;
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b1;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sclk;
        end
    end

    always_comb begin
        evt.cs_fall  = cs_q & ~cs_n;
        evt.cs_rise  = ~cs_q & cs_n;
        // count only inside a frame that was already open
        evt.sck_fall = sck_q & ~sclk & ~cs_q & ~cs_n;
    end
endmodule

// File: rtl/sar_serif_pwr.sv
module sar_serif_pwr
    import sar_serif_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int SD_LO   = 2,
    parameter int SD_HI   = 10,
    parameter int PU_DONE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  edge_evt_t        evt,
    output pwr_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             frame_bad
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] PU_LAST  = CNT_W'(PU_DONE - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PWR_NORMAL;
            cnt       <= '0;
            frame_bad <= 1'b0;
        end else if (evt.cs_fall) begin
            cnt       <= '0;
            frame_bad <= (state != PWR_NORMAL);
            if (state == PWR_SHUTDOWN) state <= PWR_WAKING;
        end else if (evt.sck_fall) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (state == PWR_WAKING && cnt == PU_LAST) state <= PWR_NORMAL;
        end else if (evt.cs_rise) begin
            state <= state_on_rise(state, int'(cnt), SD_LO, SD_HI);
        end
    end
endmodule

// File: rtl/sar_serif_shift.sv
module sar_serif_shift
    import sar_serif_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  edge_evt_t         evt,
    input  logic [DATA_W-1:0] sample,
    input  logic              blank,
    output logic              sdata,
    output logic              oe
);
    localparam int FRAME_W = DATA_W + LEAD_ZEROS;

    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            oe    <= 1'b0;
        end else if (evt.cs_fall) begin
            shreg <= blank ? '0 : {{LEAD_ZEROS{1'b0}}, sample};
            oe    <= 1'b1;
        end else if (evt.cs_rise) begin
            oe    <= 1'b0;
        end else if (evt.sck_fall) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

    assign sdata = shreg[FRAME_W-1];
endmodule

// File: rtl/sar_serif_model.sv
module sar_serif_model
    import sar_serif_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int CNT_W      = 5,
    parameter int SD_LO      = 2,
    parameter int SD_HI      = 10,
    parameter int PU_DONE    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              frame_invalid,
    output logic [1:0]        power_state,
    output logic [CNT_W-1:0]  edge_cnt
);
    edge_evt_t  evt;
    pwr_state_e st;

    sar_serif_edges u_edges (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .evt  (evt)
    );

    sar_serif_pwr #(
        .CNT_W   (CNT_W),
        .SD_LO   (SD_LO),
        .SD_HI   (SD_HI),
        .PU_DONE (PU_DONE)
    ) u_pwr (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .state     (st),
        .cnt       (edge_cnt),
        .frame_bad (frame_invalid)
    );

    sar_serif_shift #(
        .DATA_W     (DATA_W),
        .LEAD_ZEROS (LEAD_ZEROS)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .sample (sample_in),
        .blank  (st != PWR_NORMAL),
        .sdata  (sdata),
        .oe     (sdata_oe)
    );

    assign power_state = st;
endmodule

// File: rtl/sar_serif_model_chk.sv
module sar_serif_model_chk #(
    parameter int CNT_W   = 5,
    parameter int SD_LO   = 2,
    parameter int SD_HI   = 10,
    parameter int PU_DONE = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n,
    input logic             sdata,
    input logic             sdata_oe,
    input logic             frame_invalid,
    input logic [1:0]       power_state,
    input logic [CNT_W-1:0] edge_cnt
);
    p_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sdata_oe);

    p_cnt_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> (edge_cnt == $past(edge_cnt)));

    p_sd_window_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(power_state) == 2'd0 && power_state == 2'd1) |->
        ($past(edge_cnt) >= CNT_W'(SD_LO) && $past(edge_cnt) < CNT_W'(SD_HI)));

    p_wake_entry_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(power_state) == 2'd1 && power_state != 2'd1) |-> (power_state == 2'd2));

    p_pu_done_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(power_state) == 2'd2 && power_state == 2'd0) |-> (edge_cnt == CNT_W'(PU_DONE)));

    p_blank_data_r11: assert property (@(posedge clk) disable iff (rst)
        (frame_invalid && sdata_oe) |-> !sdata);
endmodule

bind sar_serif_model sar_serif_model_chk #(
    .CNT_W   (CNT_W),
    .SD_LO   (SD_LO),
    .SD_HI   (SD_HI),
    .PU_DONE (PU_DONE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .sdata         (sdata),
    .sdata_oe      (sdata_oe),
    .frame_invalid (frame_invalid),
    .power_state   (power_state),
    .edge_cnt      (edge_cnt)
);

// File: tb/sar_serif_model_tb.sv
module sar_serif_model_tb;
    localparam int ST_NORM = 0;
    localparam int ST_SD   = 1;
    localparam int ST_WAKE = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample_in = '0;
    logic        sdata, sdata_oe, frame_invalid;
    logic [1:0]  power_state;
    logic [4:0]  edge_cnt;

    int errors = 0;
    int checks = 0;
    int exp_state = ST_NORM;
    bit done = 0;

    always #4 clk = ~clk;

    sar_serif_model u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sample_in(sample_in),
        .sdata(sdata), .sdata_oe(sdata_oe), .frame_invalid(frame_invalid),
        .power_state(power_state), .edge_cnt(edge_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b1;
        waitn(3);
        rst = 1'b0;
        exp_state = ST_NORM;
        waitn(1);
    endtask

    // One host frame with nf serial-clock falls, all outputs predicted here.
    task automatic frame(input logic [11:0] smp, input int nf);
        bit          bad;
        int          start_st;
        logic [15:0] word;
        string       tag;
        start_st = exp_state;
        bad = (exp_state != ST_NORM);
        word = bad ? 16'h0 : {4'h0, smp};
        if (exp_state == ST_SD) exp_state = ST_WAKE;
        sample_in = smp;
        cs_n = 1'b0;
        waitn(3);
        chk("R3 oe while low", int'(sdata_oe), 1);
        chk("R11 invalid flag", int'(frame_invalid), int'(bad));
        chk("R2 first bit", int'(sdata), int'(word[15]));
        chk("R4 count cleared", int'(edge_cnt), 0);
        if (start_st == ST_SD) chk("R8 wake on fall", int'(power_state), ST_WAKE);
        for (int k = 1; k <= nf; k++) begin
            sclk = 1'b0;
            waitn(3);
            chk("R4 count", int'(edge_cnt), (k > 31) ? 31 : k);
            chk(bad ? "R11 zero data" : "R2 data bit", int'(sdata),
                (k <= 15) ? int'(word[15-k]) : 0);
            if (exp_state == ST_WAKE && k == 16) begin
                exp_state = ST_NORM;
                chk("R10 done at 16th fall", int'(power_state), ST_NORM);
            end
            sclk = 1'b1;
            waitn(3);
        end
        if (exp_state == ST_NORM) begin
            if (nf < 2)       tag = "R5 glitch rise";
            else if (nf < 10) begin tag = "R6 shutdown window"; exp_state = ST_SD; end
            else              tag = "R7 long frame";
        end else if (exp_state == ST_WAKE) begin
            if (nf < 10) begin tag = "R9 early rise"; exp_state = ST_SD; end
            else              tag = "R10 partial wake";
        end else tag = "state";
        cs_n = 1'b1;
        waitn(3);
        chk("R3 oe while high", int'(sdata_oe), 0);
        chk(tag, int'(power_state), exp_state);
    endtask

    initial begin
        do_reset();
        chk("R1 state", int'(power_state), ST_NORM);
        chk("R1 oe", int'(sdata_oe), 0);
        chk("R1 count", int'(edge_cnt), 0);
        chk("R1 invalid", int'(frame_invalid), 0);

        // rise position sweep from normal
        for (int n = 0; n < 20; n++) begin
            do_reset();
            frame(12'h5A3 + 12'(n), n);
        end

        // data patterns
        do_reset();
        frame(12'hA5C, 16);
        frame(12'hFFF, 16);
        frame(12'h001, 16);
        frame(12'h800, 16);
        frame(12'h3C7, 17);

        // saturation
        do_reset();
        frame(12'h123, 35);

        // wake-up sweep
        for (int n = 0; n < 20; n++) begin
            do_reset();
            frame(12'h777, 5);
            frame(12'h777, n);
            if (exp_state == ST_WAKE) frame(12'h777, 17);
            if (exp_state == ST_SD) begin
                frame(12'h777, 16);
            end
            frame(12'h9B4, 16);
        end

        // R12: clock activity with chip select high
        do_reset();
        frame(12'h456, 12);
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b0; waitn(3);
            sclk = 1'b1; waitn(3);
        end
        chk("R12 count held", int'(edge_cnt), 12);
        chk("R12 state held", int'(power_state), ST_NORM);
        chk("R12 oe off", int'(sdata_oe), 0);
        frame(12'h456, 4);
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b0; waitn(3);
            sclk = 1'b1; waitn(3);
        end
        chk("R12 count held in shutdown", int'(edge_cnt), 4);
        chk("R12 state held in shutdown", int'(power_state), ST_SD);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule